// File: doc/BRIEF.md
# Ultrasonic Ping and Echo Sequencer

This block runs one complete measurement cycle for a range finder that uses a single ultrasonic transducer for both sending and listening. A one-clock start request launches a square-wave burst on the drive output. During the burst the path select routes the transducer to the transmitter. Once the last carrier period has finished, the select flips to the receive amplifier. The block then waits out a blanking window so that the transducer's own ringing is never recorded.

After blanking, the block pulses an ADC conversion strobe at a fixed sample rate. Each returned 8-bit value is written to an external record buffer, together with its sample index. The sample rate has no relation to the carrier. When the last sample has been written, a one-clock done pulse is issued and the block returns to idle. From idle it accepts the next start request, even in the same cycle as done.

Both time bases come from the system clock through integer dividers that are parameters. With a 100 MHz clock, a half carrier period of 1250 clocks gives 40 kHz. A sample period of 5556 clocks gives about 18 kHz.

Top module: `sonar_sequencer`

## Requirements
- R1: After reset, and while idle, the outputs are: path_rx_o = 1 (receive path), tx_drive_o = 0, adc_strobe_o = 0, wr_en_o = 0, done_o = 0.
- R2: When start_i is high in an idle cycle, the next cycle has path_rx_o = 0 and tx_drive_o = 1. The drive then alternates between high and low, each level lasting exactly HALF_DIV clocks, for BURST_CYCLES full periods that begin with the high half.
- R3: path_rx_o returns to 1 in the clock after the final low half of the burst ends, and not earlier. The burst therefore lasts 2*BURST_CYCLES*HALF_DIV clocks.
- R4: tx_drive_o is 0 in every cycle in which path_rx_o is 1.
- R5: The first adc_strobe_o pulse occurs exactly (BLANK_TICKS+1)*SAMP_DIV clocks after the first receive cycle. No strobe is issued inside that blanking window.
- R6: adc_strobe_o pulses are one clock wide and SAMP_DIV clocks apart. Exactly REC_LEN pulses are issued per measurement.
- R7: One clock after each strobe, wr_en_o is 1. In that cycle wr_data_o equals the adc_data_i value present during the strobe cycle, and wr_addr_o equals the sample index, counting 0, 1, … REC_LEN-1.
- R8: done_o is high for exactly one clock, the clock after the write of index REC_LEN-1. The block is idle in that cycle.
- R9: start_i has no effect while a burst, blanking window or sample run is in progress. Output timing continues as if start had stayed low.
- R10: If start_i is high in the done cycle, or is held high across it, a new burst begins in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Measurement request, sampled only while idle |
| tx_drive_o | output | 1 | Square-wave drive to the transmit stage |
| path_rx_o | output | 1 | Transducer routing: 0 transmit, 1 receive |
| adc_strobe_o | output | 1 | One-clock conversion request to the ADC |
| adc_data_i | input | DATA_W | Converted echo amplitude |
| wr_en_o | output | 1 | Record buffer write enable |
| wr_addr_o | output | AW | Sample index of the write |
| wr_data_o | output | DATA_W | Sample value written |
| done_o | output | 1 | One-clock end-of-measurement pulse |

## Verification
A divider or phase counter that is off by one shows up quickly. Either a drive level has the wrong length within the first half period, or the first strobe lands away from its computed cycle. Because every later event is measured from those edges, the error also displaces every subsequent strobe and write. A wrong sample index or a stale data capture appears on the very next write as a mismatched address or value. A sequencer that wrongly accepts a start while busy restarts the burst, so path_rx_o drops back to transmit within one clock. The reference model compares every output on every clock, so each of these faults is reported within a cycle of first appearing.

// File: rtl/sonar_pkg.sv
package sonar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_BLANK  = 2'd2,
        ST_LISTEN = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sonar_tick_gen.sv
module sonar_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    assign tick = !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/sonar_sequencer.sv
module sonar_sequencer
    import sonar_pkg::*;
#(
    parameter int HALF_DIV     = 1250,
    parameter int SAMP_DIV     = 5556,
    parameter int BURST_CYCLES = 40,
    parameter int BLANK_TICKS  = 52,
    parameter int REC_LEN      = 256,
    parameter int DATA_W       = 8,
    localparam int AW          = $clog2(REC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              tx_drive_o,
    output logic              path_rx_o,
    output logic              adc_strobe_o,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o
);
    localparam int HALVES = 2 * BURST_CYCLES;
    localparam int HW     = $clog2(HALVES + 1);
    localparam int BW     = $clog2(BLANK_TICKS + 1);
    localparam int CW     = $clog2(REC_LEN + 1);

    typedef struct packed {
        seq_state_e        state;
        logic              tx_lvl;
        logic [HW-1:0]     half_cnt;
        logic [BW-1:0]     blank_cnt;
        logic [CW-1:0]     strobe_cnt;
        logic              strobe;
        logic              wr_en;
        logic [AW-1:0]     wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      car_tick, smp_tick;
    logic      car_clr, smp_clr;

    // Carrier half-period timer runs only during the burst.
    assign car_clr = (r_q.state != ST_BURST);
    // Sample timer runs through blanking and listening without restart.
    assign smp_clr = (r_q.state == ST_IDLE) || (r_q.state == ST_BURST);

    sonar_tick_gen #(.DIV(HALF_DIV)) u_car_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (car_clr),
        .tick  (car_tick)
    );

    sonar_tick_gen #(.DIV(SAMP_DIV)) u_smp_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (smp_clr),
        .tick  (smp_tick)
    );

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;
        r_d.wr_en  = 1'b0;
        r_d.done   = 1'b0;

        // Capture the converted value one clock after the strobe.
        if (r_q.strobe) begin
            r_d.wr_en   = 1'b1;
            r_d.wr_addr = AW'(r_q.strobe_cnt - CW'(1));
            r_d.wr_data = adc_data_i;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_BURST;
                    r_d.tx_lvl   = 1'b1;
                    r_d.half_cnt = '0;
                end
            end
            ST_BURST: begin
                if (car_tick) begin
                    if (r_q.half_cnt == HW'(HALVES - 1)) begin
                        r_d.state     = ST_BLANK;
                        r_d.tx_lvl    = 1'b0;
                        r_d.blank_cnt = '0;
                    end else begin
                        r_d.tx_lvl   = !r_q.tx_lvl;
                        r_d.half_cnt = r_q.half_cnt + HW'(1);
                    end
                end
            end
            ST_BLANK: begin
                if (smp_tick) begin
                    if (r_q.blank_cnt == BW'(BLANK_TICKS - 1)) begin
                        r_d.state      = ST_LISTEN;
                        r_d.strobe_cnt = '0;
                    end else begin
                        r_d.blank_cnt = r_q.blank_cnt + BW'(1);
                    end
                end
            end
            ST_LISTEN: begin
                if (smp_tick && r_q.strobe_cnt != CW'(REC_LEN)) begin
                    r_d.strobe     = 1'b1;
                    r_d.strobe_cnt = r_q.strobe_cnt + CW'(1);
                end
                if (r_q.wr_en && r_q.wr_addr == AW'(REC_LEN - 1)) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_drive_o   = r_q.tx_lvl;
    assign path_rx_o    = (r_q.state != ST_BURST);
    assign adc_strobe_o = r_q.strobe;
    assign wr_en_o      = r_q.wr_en;
    assign wr_addr_o    = r_q.wr_addr;
    assign wr_data_o    = r_q.wr_data;
    assign done_o       = r_q.done;
endmodule

// File: rtl/sonar_sequencer_chk.sv
module sonar_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_drive_o,
    input logic path_rx_o,
    input logic adc_strobe_o,
    input logic wr_en_o,
    input logic done_o
);
    // R4: no drive while the receive path is selected
    a_r4_quiet_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
        path_rx_o |-> !tx_drive_o);

    // R2: a burst opens on the high half
    a_r2_burst_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(path_rx_o) |-> tx_drive_o);

    // R3: switch to receive only after a low half has just ended
    a_r3_switch_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(path_rx_o) |-> !$past(tx_drive_o));

    // R6: strobe is a single-clock pulse
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |=> !adc_strobe_o);

    // R7: every strobe is followed by a write, and every write by a strobe before it
    a_r7_write_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |=> wr_en_o);
    a_r7_write_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(adc_strobe_o));

    // R8: done is one clock wide and follows a write
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_en_o));
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind sonar_sequencer sonar_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_drive_o   (tx_drive_o),
    .path_rx_o    (path_rx_o),
    .adc_strobe_o (adc_strobe_o),
    .wr_en_o      (wr_en_o),
    .done_o       (done_o)
);

// File: tb/sonar_sequencer_tb.sv
module sonar_sequencer_tb_top;
    localparam int HD = 3;
    localparam int SD = 5;
    localparam int BC = 4;
    localparam int BT = 3;
    localparam int RL = 8;
    localparam int AW = $clog2(RL);

    localparam int TXLEN  = 2 * BC * HD;
    localparam int FIRST  = TXLEN + (BT + 1) * SD;
    localparam int DONE_R = FIRST + (RL - 1) * SD + 2;
    localparam int NCYC   = 520;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    adc_data_i = 8'h00;
    logic          tx_drive_o, path_rx_o, adc_strobe_o, wr_en_o, done_o;
    logic [AW-1:0] wr_addr_o;
    logic [7:0]    wr_data_o;

    always #5 clk = ~clk;

    sonar_sequencer #(
        .HALF_DIV(HD), .SAMP_DIV(SD), .BURST_CYCLES(BC),
        .BLANK_TICKS(BT), .REC_LEN(RL), .DATA_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tx_drive_o(tx_drive_o), .path_rx_o(path_rx_o),
        .adc_strobe_o(adc_strobe_o), .adc_data_i(adc_data_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .done_o(done_o)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Start schedule: single pulse, pulses while busy, pulse on the done
    // cycle, then a long held request.
    function automatic bit start_plan(input int n);
        return (n == 5) || (n == 20) || (n == 40) || (n == 70) || (n == 87) ||
               (n == 120) || (n >= 200 && n < 420);
    endfunction

    initial begin
        bit      started = 0;
        int      t0 = 0;
        byte unsigned q[$];
        int      r, k;
        bit      e_path, e_tx, e_stb, e_wr, e_done;
        int      e_addr, e_data;

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "path_rx in reset", int'(path_rx_o), 1);
        chk("R1", "tx_drive in reset", int'(tx_drive_o), 0);
        chk("R1", "strobe in reset", int'(adc_strobe_o), 0);
        chk("R1", "wr_en in reset", int'(wr_en_o), 0);
        chk("R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;

        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            r = n - t0;
            e_path = 1; e_tx = 0; e_stb = 0; e_wr = 0; e_done = 0;
            e_addr = -1; e_data = -1;
            if (started) begin
                if (r < TXLEN) begin
                    e_path = 0;
                    e_tx   = ((r / HD) % 2) == 0;
                end
                if (r >= FIRST && (r - FIRST) % SD == 0 && (r - FIRST) / SD < RL)
                    e_stb = 1;
                if (r >= FIRST + 1 && (r - FIRST - 1) % SD == 0) begin
                    k = (r - FIRST - 1) / SD;
                    if (k < RL) begin
                        e_wr = 1;
                        e_addr = k;
                    end
                end
                e_done = (r == DONE_R);
            end

            chk(started ? "R2/R3" : "R1", "path_rx", int'(path_rx_o), int'(e_path));
            chk(e_path ? "R4" : "R2", "tx_drive", int'(tx_drive_o), int'(e_tx));
            chk((started && r < FIRST) ? "R5" : "R6", "adc_strobe", int'(adc_strobe_o), int'(e_stb));
            chk("R7", "wr_en", int'(wr_en_o), int'(e_wr));
            if (e_wr) begin
                e_data = (q.size() > 0) ? int'(q.pop_front()) : -1;
                chk("R7", "wr_addr", int'(wr_addr_o), e_addr);
                chk("R7", "wr_data", int'(wr_data_o), e_data);
            end
            chk("R8", "done", int'(done_o), int'(e_done));

            // Drive inputs for the next edge.
            adc_data_i = 8'((n * 37 + 11) & 255);
            if (e_stb) q.push_back(adc_data_i);
            start_i = start_plan(n);
            // R9/R10: a request counts only when the block is idle now.
            if (start_i && (!started || r >= DONE_R)) begin
                started = 1;
                t0 = n + 1;
            end
        end
        chk("R7", "unconsumed samples", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule